// File: doc/BRIEF.md
# Thermal Runaway Trend Detector

This block watches a stream of on-chip temperature readings and decides when the die is in thermal runaway. It does not compare against a threshold. It looks at the shape of the curve. A reading counts toward runaway when it is above the one before it, and when its rise is larger than the rise between the two readings before that. In other words, the temperature is climbing and the climb is getting faster: the discrete second derivative is positive. The readings come from a sensor path that delivers one word per update interval, typically tens of thousands of clocks apart. The block expects the readings to be equally spaced in time and does not time them itself.

The block keeps the two previous readings. It evaluates each new reading against them in the cycle the reading arrives. The first reading that meets both conditions sets a sticky runaway flag and captures that reading's temperature. While a throttling mechanism is engaged, a rising and accelerating curve does not prove runaway, because the throttling may still be taking effect. In that case the block raises a separate candidate indication instead. Each reading is also compared against a programmable maximum, which is 110 °C after reset.

Temperatures are unsigned fixed point with four fractional bits, in steps of 1/16 °C.

Top module: `thermal_accel_watch`

## Requirements
- R1: After reset, runaway_o, candidate_o and over_limit_o are 0, runaway_temp_o is 0, and the limit holds 1760 (110 °C in 1/16 °C units).
- R2: No runaway or candidate is reported for the first two readings accepted after reset. A decision needs a reading plus two earlier ones.
- R3: A reading is a runaway hit when it is strictly greater than the previous reading, and its increment over that reading is strictly greater than the previous increment. Increments are computed as signed values one bit wider than the temperature. A hit accepted with throttle_i low sets runaway_o on the clock edge that accepts it.
- R4: An increment equal to the previous increment is not a hit. A reading that is not above the previous one is not a hit, even if its increment exceeds the previous increment (for example a slowing fall).
- R5: With throttle_i high when the reading is accepted, a hit sets candidate_o and never sets runaway_o. candidate_o is rewritten by every accepted reading to whether that reading was a throttled hit.
- R6: runaway_o stays set once set. runaway_temp_o holds the reading of the first hit and is not changed by later hits.
- R7: A clr_i pulse clears runaway_o, candidate_o and runaway_temp_o on the next edge. If a hit arrives in the same cycle, the clear wins. The stored reading history is kept and still advances with that reading.
- R8: On each accepted reading, over_limit_o becomes 1 when the reading is strictly greater than the limit, and 0 otherwise. It holds until the next accepted reading.
- R9: A cycle with lim_we_i high loads lim_dat_i into the limit. Readings accepted in later cycles are compared against the new value.
- R10: While smp_vld_i is low, smp_temp_i and throttle_i are ignored. No output changes (apart from a clear), and the reading history is untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Strobe: smp_temp_i holds a new reading |
| smp_temp_i | input | TW (12) | Reading, unsigned, 1/16 °C per step |
| throttle_i | input | 1 | Throttling is engaged for this reading |
| clr_i | input | 1 | Clear the runaway flag, candidate and captured temperature |
| lim_we_i | input | 1 | Load the limit from lim_dat_i |
| lim_dat_i | input | TW (12) | New limit value |
| runaway_o | output | 1 | Sticky runaway indication |
| candidate_o | output | 1 | Last reading was a hit while throttled |
| runaway_temp_o | output | TW (12) | Reading of the first runaway hit |
| over_limit_o | output | 1 | Last reading exceeded the limit |

## Verification
Most of the state sits in the two-reading history. A stale or misordered history entry does not show at the ports on the reading that corrupts it. It shows one or two readings later, as a wrong hit or a missed hit. The bench therefore sweeps every pair of successive increments from -4 to +4 steps, with throttling both off and on, and compares all four outputs after every reading. A broken warm-up counter shows on the first or second reading after reset. A capture register that is updated too freely shows as a changed runaway_temp_o on the first hit after the one that set the flag.

// File: rtl/trw_pkg.sv
package trw_pkg;
   localparam int TEMP_W_DEF = 12;
   localparam int FRAC_W_DEF = 4;
   localparam int LIMIT_DEF  = 110 * (1 << FRAC_W_DEF);

   typedef struct packed {
      logic ready;   // two earlier readings are held
      logic rise;    // newest increment is positive
      logic accel;   // newest increment beats the earlier one
   } trend_t;
endpackage

// File: rtl/trw_history.sv
module trw_history #(
   parameter int TW   = 12,
   parameter int HIST = 2
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     push_i,
   input  logic [TW-1:0]            din_i,
   output logic [HIST-1:0][TW-1:0]  tap_o,
   output logic                     full_o
);
   localparam int CW = $clog2(HIST + 1);

   logic [CW-1:0] cnt_q;

   assign full_o = (cnt_q == CW'(HIST));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (push_i && !full_o) cnt_q <= cnt_q + 1'b1;
   end

   for (genvar i = 0; i < HIST; i++) begin : g_tap
      if (i == 0) begin : g_head
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     tap_o[0] <= '0;
            else if (push_i) tap_o[0] <= din_i;
         end
      end else begin : g_body
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     tap_o[i] <= '0;
            else if (push_i) tap_o[i] <= tap_o[i-1];
         end
      end
   end
endmodule

// File: rtl/trw_trend.sv
module trw_trend
   import trw_pkg::*;
#(
   parameter int TW = 12
) (
   input  logic [TW-1:0] sample_i,
   input  logic [TW-1:0] newest_i,
   input  logic [TW-1:0] older_i,
   input  logic          ready_i,
   output trend_t        verdict_o
);
   localparam int DW = TW + 1;

   logic signed [DW-1:0] d_new, d_old;

   assign d_new = $signed({1'b0, sample_i}) - $signed({1'b0, newest_i});
   assign d_old = $signed({1'b0, newest_i}) - $signed({1'b0, older_i});

   always_comb begin
      verdict_o.ready = ready_i;
      verdict_o.rise  = !d_new[DW-1] && (d_new != '0);
      verdict_o.accel = d_new > d_old;
   end
endmodule

// File: rtl/trw_latch.sv
module trw_latch
   import trw_pkg::*;
#(
   parameter int TW = 12
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          take_i,
   input  logic          clr_i,
   input  logic          thr_i,
   input  trend_t        verdict_i,
   input  logic [TW-1:0] sample_i,
   output logic          run_o,
   output logic          cand_o,
   output logic [TW-1:0] temp_o
);
   logic hit;

   assign hit = verdict_i.ready & verdict_i.rise & verdict_i.accel;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_o  <= 1'b0;
         cand_o <= 1'b0;
         temp_o <= '0;
      end else if (clr_i) begin
         run_o  <= 1'b0;
         cand_o <= 1'b0;
         temp_o <= '0;
      end else if (take_i) begin
         cand_o <= hit & thr_i;
         if (hit && !thr_i && !run_o) begin
            run_o  <= 1'b1;
            temp_o <= sample_i;
         end
      end
   end
endmodule

// File: rtl/thermal_accel_watch.sv
module thermal_accel_watch
   import trw_pkg::*;
#(
   parameter int TW         = TEMP_W_DEF,
   parameter int FRAC       = FRAC_W_DEF,
   parameter int LIMIT_RST  = LIMIT_DEF,
   parameter bit LIMIT_INCL = 1'b0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          smp_vld_i,
   input  logic [TW-1:0] smp_temp_i,
   input  logic          throttle_i,
   input  logic          clr_i,
   input  logic          lim_we_i,
   input  logic [TW-1:0] lim_dat_i,
   output logic          runaway_o,
   output logic          candidate_o,
   output logic [TW-1:0] runaway_temp_o,
   output logic          over_limit_o
);
   localparam int HIST = 2;

   if (TW < FRAC + 8) begin : g_bad_width
      $error("thermal_accel_watch: TW too narrow for the fraction width");
   end
   if (LIMIT_RST >= (1 << TW)) begin : g_bad_limit
      $error("thermal_accel_watch: LIMIT_RST does not fit in TW bits");
   end

   logic [HIST-1:0][TW-1:0] tap;
   logic                    hist_full;
   trend_t                  verdict;
   logic [TW-1:0]           lim_q;
   logic                    exceed;

   trw_history #(.TW(TW), .HIST(HIST)) u_hist (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (smp_vld_i),
      .din_i  (smp_temp_i),
      .tap_o  (tap),
      .full_o (hist_full)
   );

   trw_trend #(.TW(TW)) u_trend (
      .sample_i  (smp_temp_i),
      .newest_i  (tap[0]),
      .older_i   (tap[1]),
      .ready_i   (hist_full),
      .verdict_o (verdict)
   );

   trw_latch #(.TW(TW)) u_latch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .take_i    (smp_vld_i),
      .clr_i     (clr_i),
      .thr_i     (throttle_i),
      .verdict_i (verdict),
      .sample_i  (smp_temp_i),
      .run_o     (runaway_o),
      .cand_o    (candidate_o),
      .temp_o    (runaway_temp_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       lim_q <= TW'(LIMIT_RST);
      else if (lim_we_i) lim_q <= lim_dat_i;
   end

   if (LIMIT_INCL) begin : g_cmp_incl
      assign exceed = (smp_temp_i >= lim_q);
   end else begin : g_cmp_strict
      assign exceed = (smp_temp_i > lim_q);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        over_limit_o <= 1'b0;
      else if (smp_vld_i) over_limit_o <= exceed;
   end
endmodule

// File: rtl/trw_checker.sv
module trw_checker #(
   parameter int TW   = 12,
   parameter bit INCL = 1'b0
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          smp_vld_i,
   input logic [TW-1:0] smp_temp_i,
   input logic          throttle_i,
   input logic          clr_i,
   input logic          runaway_o,
   input logic          candidate_o,
   input logic [TW-1:0] runaway_temp_o,
   input logic          over_limit_o,
   input logic          full_i,
   input logic [TW-1:0] lim_i
);
   p_warmup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_vld_i && !full_i && !runaway_o |=> !runaway_o && !candidate_o);

   p_throttle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_vld_i && throttle_i && !runaway_o |=> !runaway_o);

   p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      runaway_o && !clr_i |=> runaway_o);

   p_temp_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      runaway_o && !clr_i |=> $stable(runaway_temp_o));

   p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !runaway_o && !candidate_o && (runaway_temp_o == '0));

   p_limit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_vld_i |=> over_limit_o == (INCL ? ($past(smp_temp_i) >= $past(lim_i))
                                          : ($past(smp_temp_i) >  $past(lim_i))));

   p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !smp_vld_i && !clr_i |=> $stable(over_limit_o) && $stable(candidate_o)
                               && $stable(runaway_o) && $stable(runaway_temp_o));
endmodule

bind thermal_accel_watch trw_checker #(.TW(TW), .INCL(LIMIT_INCL)) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .smp_vld_i      (smp_vld_i),
   .smp_temp_i     (smp_temp_i),
   .throttle_i     (throttle_i),
   .clr_i          (clr_i),
   .runaway_o      (runaway_o),
   .candidate_o    (candidate_o),
   .runaway_temp_o (runaway_temp_o),
   .over_limit_o   (over_limit_o),
   .full_i         (hist_full),
   .lim_i          (lim_q)
);

// File: tb/sim_thermal_accel_watch.sv
`timescale 1ns/1ps
module sim_thermal_accel_watch;
   localparam int TW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          vld = 1'b0;
   logic [TW-1:0] temp = '0;
   logic          thr = 1'b0;
   logic          clr = 1'b0;
   logic          lwe = 1'b0;
   logic [TW-1:0] ldat = '0;
   logic          run, cand, ovl;
   logic [TW-1:0] rtemp;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // bench-side reference state
   int m_h0 = 0, m_h1 = 0, m_cnt = 0;
   int m_run = 0, m_cand = 0, m_temp = 0, m_ovl = 0, m_lim = 1760;

   always #2.5 clk = ~clk;

   thermal_accel_watch u0 (
      .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .smp_temp_i(temp),
      .throttle_i(thr), .clr_i(clr), .lim_we_i(lwe), .lim_dat_i(ldat),
      .runaway_o(run), .candidate_o(cand), .runaway_temp_o(rtemp),
      .over_limit_o(ovl)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      check(req, "runaway_o", int'(run), m_run);
      check(req, "candidate_o", int'(cand), m_cand);
      check(req, "runaway_temp_o", int'(rtemp), m_temp);
      check(req, "over_limit_o", int'(ovl), m_ovl);
   endtask

   task automatic step(input int t, input bit th, input bit cl, input bit v, input string req);
      int d_new, d_old;
      bit hit;
      temp = TW'(t); thr = th; clr = cl; vld = v;
      @(posedge clk);
      if (v) begin
         d_new = t - m_h0;
         d_old = m_h0 - m_h1;
         hit = (m_cnt >= 2) && (d_new > 0) && (d_new > d_old);
         m_ovl = (t > m_lim) ? 1 : 0;
         if (!cl) begin
            m_cand = (hit && th) ? 1 : 0;
            if (hit && !th && m_run == 0) begin
               m_run = 1; m_temp = t;
            end
         end
         m_h1 = m_h0; m_h0 = t;
         if (m_cnt < 2) m_cnt++;
      end
      if (cl) begin
         m_run = 0; m_cand = 0; m_temp = 0;
      end
      @(negedge clk);
      vld = 1'b0; clr = 1'b0;
      check_all(req);
   endtask

   task automatic set_limit(input int l);
      ldat = TW'(l); lwe = 1'b1;
      @(posedge clk);
      m_lim = l;
      @(negedge clk);
      lwe = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_all("R1");

      // R9/R1: reset limit is 1760: 1761 exceeds, 1760 does not
      step(1761, 0, 0, 1, "R1");
      step(1760, 0, 0, 1, "R8");

      // R2: warm-up, then R3 hit on the third reading after reset
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      m_h0 = 0; m_h1 = 0; m_cnt = 0; m_run = 0; m_cand = 0; m_temp = 0; m_ovl = 0; m_lim = 1760;
      @(negedge clk);
      step(100, 0, 0, 1, "R2");
      step(500, 0, 0, 1, "R2");
      step(1000, 0, 0, 1, "R3");
      check("R3", "runaway_o", int'(run), 1);
      check("R3", "runaway_temp_o", int'(rtemp), 1000);

      // R6: a later hit keeps the first captured reading
      step(1600, 0, 0, 1, "R6");
      check("R6", "runaway_temp_o", int'(rtemp), 1000);

      // R7: clear alone, then clear together with a hit
      step(0, 0, 1, 0, "R7");
      step(2300, 0, 1, 1, "R7");
      check("R7", "runaway_o", int'(run), 0);
      step(3100, 0, 0, 1, "R7");
      check("R7", "runaway_temp_o", int'(rtemp), 3100);

      // R10: ignored inputs while the strobe is low, history preserved
      step(0, 0, 1, 0, "R7");
      step(4000, 1, 0, 0, "R10");
      step(5, 0, 0, 0, "R10");
      step(3950, 1, 0, 0, "R10");
      step(4000, 0, 0, 1, "R10");
      check("R10", "runaway_temp_o", int'(rtemp), 4000);

      // R9: limit write takes effect for later readings
      set_limit(300);
      step(301, 0, 0, 1, "R9");
      check("R9", "over_limit_o", int'(ovl), 1);
      step(300, 0, 0, 1, "R9");
      check("R9", "over_limit_o", int'(ovl), 0);
      set_limit(1760);

      // R3 R4 R5 R8: sweep of increment pairs, throttle off and on
      for (int th = 0; th < 2; th++) begin
         for (int d0 = -4; d0 <= 4; d0++) begin
            for (int d1 = -4; d1 <= 4; d1++) begin
               step(0, 0, 1, 0, "R7");
               step(1755, th[0], 0, 1, "R8");
               step(1755 + d0, th[0], 0, 1, "R4");
               step(1755 + d0 + d1, th[0], 0, 1, th ? "R5" : "R3");
            end
         end
      end

      finish_run();
   end
endmodule